// File: doc/BRIEF.md
# Host-Adapter Interrupt Aggregator

This block merges interrupt causes from up to six storage ports into a single request to the host. Each port keeps a 32-bit cause word and a 32-bit enable word. A port counts as pending when the two words share a set bit. The pending flags of all ports form a global summary bitmap. When that bitmap is nonzero and the global interrupt enable is on, the block signals the host in one of two ways. In message mode it sends a one-cycle request pulse. In pin mode it drives a level line.

Software reaches the block through a write-only register port. A write to the global control word either sets the interrupt enable or resets the controller. Writes to a port's cause word clear the bits that are written as 1. Writes to a port's enable word store the value through a fixed mask. Ports set cause bits by pulsing `port_evt`. The block re-evaluates the interrupt condition in the clock cycle after any register write or port event. A separate bus master turns each pulse on `msi_req` into a message transaction.

Register addresses on `wr_addr`: 0 is the global control word. For port p, the cause word is at 2+2p and the enable word is at 3+2p.

Top module: `hba_irq_merge`

## Requirements
- R1: Bit p of `glb_is` is 1 exactly when port p's cause word AND its enable word is nonzero, as of the last evaluation.
- R2: Neither `msi_req` nor a rising `intx_out` occurs unless `glb_is` is nonzero and the interrupt-enable bit (control bit 1) is set.
- R3: When `msi_mode` is 1, every evaluation that finds an enabled pending interrupt gives a `msi_req` pulse that lasts exactly one cycle. A later evaluation, caused by any write, gives a fresh pulse.
- R4: When `msi_mode` is 0, an evaluation that finds an enabled pending interrupt raises `intx_out`. Further evaluations hold it at 1 while the interrupt stays pending.
- R5: `intx_out` falls at an evaluation that finds no pending port or finds the interrupt enable cleared.
- R6: A write to a port enable word stores only the bits of 0xFDC000FF. A cause bit in positions 8 to 21 or 25 can never make that port pending.
- R7: Writing 1 to a bit of a port cause word clears that bit. Bits written as 0 are kept. `port_evt` bits set cause bits.
- R8: Writing control bit 0 (host reset) clears the interrupt enable and drops `intx_out` at that clock edge. It leaves `glb_ctl` equal to 0x80000000, where bit 31 is the always-set controller-enable bit.
- R9: Outputs update at the second clock edge after a write or event is presented. A change of `msi_mode` alone starts no evaluation.
- R10: After reset, `msi_req`, `intx_out` and `glb_is` are 0 and `glb_ctl` is 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | 32 | Write data |
| port_evt | input | NPORTS*32 | Per-port cause set pulses, port p in bits 32p+31..32p |
| msi_mode | input | 1 | 1 selects message signalling, 0 selects the level pin |
| msi_req | output | 1 | One-cycle message request |
| intx_out | output | 1 | Level interrupt line |
| glb_is | output | NPORTS | Global pending bitmap |
| glb_ctl | output | 32 | Global control word |

## Verification
A table of vectors drives a single port at a time. The vectors cover overlapping and disjoint cause/enable pairs, both signalling modes, and the global enable both on and off. Together they separate the summary bitmap from the gating of the output. Some cause bits fall inside the enable mask and some outside it, so a wrong mask constant shows up as a missed or false pending flag. Directed sequences then test the following:
- pulse width, and a fresh pulse on re-evaluation;
- the pin line held across unrelated writes;
- partial write-1-to-clear;
- host reset while the line is asserted;
- a mode change made with no trigger.

// File: rtl/hba_irq_merge.sv
module hba_irq_merge #(
  parameter int          NPORTS  = 6,
  parameter int          AW      = $clog2(2*NPORTS+2),
  parameter logic [31:0] EN_MASK = 32'hFDC0_00FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [NPORTS*32-1:0] port_evt,
  input  logic                 msi_mode,
  output logic                 msi_req,
  output logic                 intx_out,
  output logic [NPORTS-1:0]    glb_is,
  output logic [31:0]          glb_ctl
);
  localparam int RST_BIT = 0;
  localparam int IEN_BIT = 1;

  logic              ien_q;
  logic              eval_q;
  logic [NPORTS-1:0] hit;

  wire ctl_wr = wr_en && (wr_addr == '0);
  wire hr_wr  = ctl_wr && wr_data[RST_BIT];
  wire kick   = wr_en || (|port_evt);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [31:0] cause_q;
    logic [31:0] en_q;
    wire cause_sel = wr_en && (wr_addr == AW'(2 + 2*i));
    wire en_sel    = wr_en && (wr_addr == AW'(3 + 2*i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause_q <= '0;
        en_q    <= '0;
      end else begin
        cause_q <= (cause_sel ? (cause_q & ~wr_data) : cause_q) | port_evt[i*32 +: 32];
        if (en_sel) en_q <= wr_data & EN_MASK;
      end
    end

    assign hit[i] = |(cause_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= kick;
      if (hr_wr)       ien_q <= 1'b0;
      else if (ctl_wr) ien_q <= wr_data[IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_is   <= '0;
      msi_req  <= 1'b0;
      intx_out <= 1'b0;
    end else begin
      msi_req <= 1'b0;
      if (eval_q) begin
        glb_is <= hit;
        if ((|hit) && ien_q) begin
          if (msi_mode)       msi_req  <= 1'b1;
          else if (!intx_out) intx_out <= 1'b1;
        end else begin
          intx_out <= 1'b0;
        end
      end
      if (hr_wr) intx_out <= 1'b0;
    end
  end

  assign glb_ctl = {1'b1, 29'd0, ien_q, 1'b0};
endmodule

// File: rtl/hba_irq_merge_chk.sv
module hba_irq_merge_chk #(
  parameter int NPORTS = 6,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              rst_bit,
  input logic              msi_mode,
  input logic              msi_req,
  input logic              intx_out,
  input logic [NPORTS-1:0] glb_is,
  input logic              ien
);
  AST_MSI_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> (glb_is != '0) && $past(ien)); // R2

  AST_MSI_ONLY_IN_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msi_mode)); // R3

  AST_INTX_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intx_out) |-> $past(ien) && !$past(msi_mode) && (glb_is != '0)); // R4

  AST_INTX_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    intx_out |-> (glb_is != '0)); // R5

  AST_HOST_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (wr_addr == '0) && rst_bit) |-> !intx_out && !ien); // R8
endmodule

bind hba_irq_merge hba_irq_merge_chk #(.NPORTS(NPORTS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rst_bit(wr_data[0]), .msi_mode(msi_mode), .msi_req(msi_req),
  .intx_out(intx_out), .glb_is(glb_is), .ien(ien_q)
);

// File: tb/hba_irq_merge_tb.sv
module hba_irq_merge_tb;
  localparam int NP = 6;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NP*32-1:0] port_evt = '0;
  logic msi_mode = 1'b0;
  logic msi_req, intx_out;
  logic [NP-1:0] glb_is;
  logic [31:0] glb_ctl;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hba_irq_merge u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .port_evt(port_evt), .msi_mode(msi_mode), .msi_req(msi_req),
    .intx_out(intx_out), .glb_is(glb_is), .glb_ctl(glb_ctl)
  );

  typedef struct packed {
    logic        msi;
    logic        gie;
    logic [2:0]  port;
    logic [31:0] en;
    logic [31:0] evt;
    logic [5:0]  glb;
    logic        intx;
    logic        req;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{1'b0, 1'b1, 3'd0, 32'h0000_0001, 32'h0000_0001, 6'b000001, 1'b1, 1'b0},
    '{1'b1, 1'b1, 3'd3, 32'h0000_0080, 32'h0000_0080, 6'b001000, 1'b0, 1'b1},
    '{1'b0, 1'b0, 3'd2, 32'h0000_0001, 32'h0000_0001, 6'b000100, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd5, 32'h0000_000F, 32'h0000_0010, 6'b000000, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0000_0400, 6'b000000, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF, 32'h0200_0000, 6'b000000, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF, 32'h0040_0000, 6'b010000, 1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd5, 32'h0000_0002, 32'h0000_0002, 6'b100000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 3'd5, 32'h8000_0000, 32'h8000_0000, 6'b100000, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt(input int p, input logic [31:0] v);
    @(negedge clk);
    port_evt[p*32 +: 32] = v;
    @(negedge clk);
    port_evt = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) begin
      wr(2 + 2*p, 32'hFFFF_FFFF);
      wr(3 + 2*p, 32'h0);
    end
    wr(0, 32'h0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 msi_req", {31'd0, msi_req}, 32'd0);
    chk("R10 intx_out", {31'd0, intx_out}, 32'd0);
    chk("R10 glb_is", {26'd0, glb_is}, 32'd0);
    rst_n = 1'b1;
    settle();
    chk("R10 glb_ctl", glb_ctl, 32'h8000_0000);

    // Vector table: R1 R2 R3 R4 R6
    for (int k = 0; k < 9; k++) begin
      clear_all();
      msi_mode = VT[k].msi;
      wr(3 + 2*VT[k].port, VT[k].en);
      wr(0, {30'd0, VT[k].gie, 1'b0});
      evt(VT[k].port, VT[k].evt);
      settle();
      chk($sformatf("R1 vec%0d glb_is", k), {26'd0, glb_is}, {26'd0, VT[k].glb});
      chk($sformatf("R4 vec%0d intx", k), {31'd0, intx_out}, {31'd0, VT[k].intx});
      chk($sformatf("R3 vec%0d msi", k), {31'd0, msi_req}, {31'd0, VT[k].req});
    end

    // R3: one-cycle pulse, fresh pulse on a later evaluation
    settle();
    chk("R3 pulse ends", {31'd0, msi_req}, 32'd0);
    wr(3, 32'h0);
    settle();
    chk("R3 repulse", {31'd0, msi_req}, 32'd1);
    settle();
    chk("R3 repulse ends", {31'd0, msi_req}, 32'd0);

    // R9: mode change alone starts no evaluation
    msi_mode = 1'b0;
    repeat (4) settle();
    chk("R9 no eval intx", {31'd0, intx_out}, 32'd0);
    msi_mode = 1'b1;
    repeat (3) settle();
    chk("R9 no eval msi", {31'd0, msi_req}, 32'd0);

    // R9: timing after an event
    clear_all();
    msi_mode = 1'b0;
    wr(3, 32'h3);
    wr(0, 32'h2);
    evt(0, 32'h3);
    chk("R9 not yet", {31'd0, intx_out}, 32'd0);
    settle();
    chk("R9 second edge", {31'd0, intx_out}, 32'd1);

    // R4: held across unrelated write
    wr(5, 32'h1);
    settle();
    chk("R4 held", {31'd0, intx_out}, 32'd1);

    // R7: partial write-1-to-clear
    wr(2, 32'h1);
    settle();
    chk("R7 partial clear keeps", {26'd0, glb_is}, 32'h1);
    wr(2, 32'h2);
    settle();
    chk("R7 full clear glb", {26'd0, glb_is}, 32'h0);
    chk("R5 drop no pending", {31'd0, intx_out}, 32'd0);

    // R5: drop on disable
    evt(0, 32'h1);
    settle();
    chk("R5 reassert", {31'd0, intx_out}, 32'd1);
    wr(0, 32'h0);
    settle();
    chk("R5 drop disabled", {31'd0, intx_out}, 32'd0);

    // R8: host reset
    wr(0, 32'h2);
    settle();
    chk("R8 pre", {31'd0, intx_out}, 32'd1);
    wr(0, 32'h3);
    chk("R8 intx drop", {31'd0, intx_out}, 32'd0);
    chk("R8 ctl word", glb_ctl, 32'h8000_0000);
    evt(0, 32'h2);
    settle();
    chk("R8 stays quiet", {31'd0, intx_out}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule